// File: doc/BRIEF.md
# Clock Start-Up Delay Sequencer

This block sits between the clock source selection and the core. It keeps the core in reset and holds the gated system clock off until the selected clock has had time to settle. The delay depends on how the sequence began. A reset request runs the long path. A wake request from power-down runs the short path.

On the long path the clock is enabled after a short count of clock cycles. The core reset is released after a further cycle count. A 2-bit start-up code can add a wait measured in ticks of a slow millisecond timer. One value of the code is reserved. With that value the block never releases reset and raises an error flag.

On the short path the clock is enabled after the short count alone, and the core reset stays released. The start-up code is captured while the reset request is high. Changes to the code after that have no effect until the next reset request.

Top module: `clk_start_seq`

## Requirements
- R1: While `rst_req` is high, `core_rst` is 1 and `clk_en` is 0. `start_code` is captured on every clock edge, so the value present at the last edge with `rst_req` high is the one used.
- R2: After `rst_req` falls, `clk_en` becomes 1 after the 6th rising clock edge sampled with `rst_req` low, and is 0 after the 5th.
- R3: With code 2'b00 there is no millisecond wait. `core_rst` becomes 0 after the 20th rising edge after release (6 + 14 cycles) and is still 1 after the 19th.
- R4: With code 2'b01, after the 20 cycles the block waits for 4 rising edges of `ms_tick`. `core_rst` stays 1 until the 4th edge has passed the two-stage synchronizer, and falls within 3 cycles after it.
- R5: With code 2'b10 the block waits in the same way for 64 rising edges of `ms_tick` before releasing `core_rst`.
- R6: With code 2'b11 (reserved), `cfg_err` is 1 and `core_rst` is never released, whatever the tick input does. `clk_en` still becomes 1 after 6 cycles.
- R7: Changing `start_code` after `rst_req` has fallen does not change the delay of the sequence in progress.
- R8: A reset request in any state restarts the long path. `core_rst` is 1 and `clk_en` is 0 one edge later, and the full timing of R2 to R6 applies again with the newly captured code.
- R9: In the running state, `pd_enter` drops `clk_en` at the next edge and leaves `core_rst` at 0.
- R10: In power-down, the edge that samples `wake_req` high starts the short path. `clk_en` becomes 1 six edges after that edge, and `core_rst` stays 0 throughout.
- R11: `wake_req` in the running state has no effect: `clk_en` stays 1 and `core_rst` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Selected clock source |
| rst_req | input | 1 | Power-on or external reset request. Synchronous, active high |
| start_code | input | 2 | Start-up delay code, captured while `rst_req` is high |
| ms_tick | input | 1 | Free-running millisecond tick from a slow timer. Asynchronous |
| wake_req | input | 1 | Wake request from power-down |
| pd_enter | input | 1 | Request to enter power-down from the running state |
| clk_en | output | 1 | Enable for the gated system clock |
| core_rst | output | 1 | Internal core reset, active high |
| cfg_err | output | 1 | Reserved start-up code captured |

## Verification
A wrong cycle counter or wrong state shows up as an early or late edge on `clk_en` or `core_rst`. The bench samples each of these edges one cycle before and one cycle after the point the requirements give, so an error of a single cycle is reported. A wrong tick count or a bad latched code moves the release of `core_rst` by a whole tick period of ten cycles, or stops it altogether. The bench catches this because it checks the state of `core_rst` after every tick delivered near the limit. A bad path flag appears at once as `core_rst` rising on a wake, or as `clk_en` never returning after power-down.

// File: rtl/clk_start_pkg.sv
package clk_start_pkg;

    typedef enum logic [1:0] {
        SU_NO_MS    = 2'b00,
        SU_MS_SHORT = 2'b01,
        SU_MS_LONG  = 2'b10,
        SU_RSVD     = 2'b11
    } su_code_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLK_WAIT,
        ST_RST_CYCLES,
        ST_MS_WAIT,
        ST_RUN
    } seq_state_e;

    typedef enum logic {
        PATH_RESET,
        PATH_WAKE
    } seq_path_e;

    typedef struct packed {
        seq_state_e state;
        seq_path_e  path;
        su_code_e   code;
        logic       released;
    } seq_reg_t;

    function automatic int unsigned ms_goal(su_code_e c, int unsigned short_ms,
                                            int unsigned long_ms);
        case (c)
            SU_MS_SHORT: return short_ms;
            SU_MS_LONG:  return long_ms;
            default:     return 0;
        endcase
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/su_tick_sync.sv
module su_tick_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_async,
    output logic tick_rise
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], tick_async};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign tick_rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/su_counter.sv
module su_counter #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (clr)
            cnt <= '0;
        else if (en)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/clk_start_seq.sv
module clk_start_seq
    import clk_start_pkg::*;
#(
    parameter int unsigned PD_CYCLES  = 6,
    parameter int unsigned RST_CYCLES = 14,
    parameter int unsigned MS_SHORT   = 4,
    parameter int unsigned MS_LONG    = 64,
    parameter int unsigned SYNC_STG   = 2
) (
    input  logic       clk,
    input  logic       rst_req,
    input  logic [1:0] start_code,
    input  logic       ms_tick,
    input  logic       wake_req,
    input  logic       pd_enter,
    output logic       clk_en,
    output logic       core_rst,
    output logic       cfg_err
);
    localparam int unsigned CW = $clog2(max2(PD_CYCLES, RST_CYCLES) + 1);
    localparam int unsigned MW = $clog2(max2(MS_SHORT, MS_LONG) + 1);

    seq_reg_t        cur, nxt;
    logic [CW-1:0]   cyc_cnt;
    logic [MW-1:0]   ms_cnt;
    logic [MW-1:0]   ms_limit;
    logic            tick_rise;
    logic            cyc_clr, cyc_en, ms_clr, ms_en;
    logic            pd_done, rst_done, ms_done;

    su_tick_sync #(.STAGES(SYNC_STG)) tick_i (
        .clk        (clk),
        .rst        (rst_req),
        .tick_async (ms_tick),
        .tick_rise  (tick_rise)
    );

    su_counter #(.W(CW)) cyc_i (
        .clk (clk),
        .clr (cyc_clr),
        .en  (cyc_en),
        .cnt (cyc_cnt)
    );

    su_counter #(.W(MW)) ms_i (
        .clk (clk),
        .clr (ms_clr),
        .en  (ms_en),
        .cnt (ms_cnt)
    );

    assign ms_limit = MW'(ms_goal(cur.code, MS_SHORT, MS_LONG));
    assign pd_done  = (cur.state == ST_CLK_WAIT)   && (cyc_cnt == CW'(PD_CYCLES - 1));
    assign rst_done = (cur.state == ST_RST_CYCLES) && (cyc_cnt == CW'(RST_CYCLES - 1));
    assign ms_done  = (cur.state == ST_MS_WAIT) && tick_rise &&
                      (cur.code != SU_RSVD) && (ms_cnt == ms_limit - 1'b1);

    always_comb begin
        nxt = cur;
        unique case (cur.state)
            ST_IDLE: begin
                if (wake_req) begin
                    nxt.state = ST_CLK_WAIT;
                    nxt.path  = PATH_WAKE;
                end
            end
            ST_CLK_WAIT: begin
                if (pd_done)
                    nxt.state = (cur.path == PATH_WAKE) ? ST_RUN : ST_RST_CYCLES;
            end
            ST_RST_CYCLES: begin
                if (rst_done) begin
                    if (cur.code == SU_NO_MS) begin
                        nxt.state    = ST_RUN;
                        nxt.released = 1'b1;
                    end else begin
                        nxt.state = ST_MS_WAIT;
                    end
                end
            end
            ST_MS_WAIT: begin
                if (ms_done) begin
                    nxt.state    = ST_RUN;
                    nxt.released = 1'b1;
                end
            end
            ST_RUN: begin
                if (pd_enter)
                    nxt.state = ST_IDLE;
            end
            default: nxt.state = ST_CLK_WAIT;
        endcase
        if (rst_req) begin
            nxt.state    = ST_CLK_WAIT;
            nxt.path     = PATH_RESET;
            nxt.code     = su_code_e'(start_code);
            nxt.released = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        cur <= nxt;
    end

    assign cyc_clr = rst_req || (nxt.state != cur.state);
    assign cyc_en  = (cur.state == ST_CLK_WAIT) || (cur.state == ST_RST_CYCLES);
    assign ms_clr  = rst_req || (cur.state != ST_MS_WAIT);
    assign ms_en   = tick_rise;

    assign clk_en   = (cur.state == ST_RST_CYCLES) || (cur.state == ST_MS_WAIT) ||
                      (cur.state == ST_RUN);
    assign core_rst = ~cur.released;
    assign cfg_err  = (cur.code == SU_RSVD);
endmodule

// File: rtl/su_seq_checker.sv
module su_seq_checker (
    input logic clk,
    input logic rst_req,
    input logic wake_req,
    input logic pd_enter,
    input logic clk_en,
    input logic core_rst,
    input logic cfg_err
);
    AST_HOLD_DURING_REQ: assert property (@(posedge clk) disable iff (rst_req)
        $fell(rst_req) |-> (core_rst && !clk_en)); // R1

    AST_RSVD_NEVER_RELEASE: assert property (@(posedge clk) disable iff (rst_req)
        cfg_err |-> core_rst); // R6

    AST_RST_ONLY_FROM_REQ: assert property (@(posedge clk) disable iff (rst_req)
        $rose(core_rst) |-> $past(rst_req)); // R8

    AST_PD_GATES_CLOCK: assert property (@(posedge clk) disable iff (rst_req)
        (clk_en && !core_rst && pd_enter) |=> (!clk_en && !core_rst)); // R9

    AST_WAKE_KEEPS_RELEASE: assert property (@(posedge clk) disable iff (rst_req)
        (!core_rst && wake_req) |=> !core_rst); // R10

    AST_RUN_IGNORES_WAKE: assert property (@(posedge clk) disable iff (rst_req)
        (clk_en && !core_rst && wake_req && !pd_enter) |=> (clk_en && !core_rst)); // R11
endmodule

bind clk_start_seq su_seq_checker chk_i (
    .clk      (clk),
    .rst_req  (rst_req),
    .wake_req (wake_req),
    .pd_enter (pd_enter),
    .clk_en   (clk_en),
    .core_rst (core_rst),
    .cfg_err  (cfg_err)
);

// File: tb/clk_start_seq_tb_top.sv
module clk_start_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_req = 1'b1;
    logic [1:0] start_code = 2'b00;
    logic       ms_tick = 1'b0;
    logic       wake_req = 1'b0;
    logic       pd_enter = 1'b0;
    logic       clk_en, core_rst, cfg_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clk_start_seq dut_i (
        .clk        (clk),
        .rst_req    (rst_req),
        .start_code (start_code),
        .ms_tick    (ms_tick),
        .wake_req   (wake_req),
        .pd_enter   (pd_enter),
        .clk_en     (clk_en),
        .core_rst   (core_rst),
        .cfg_err    (cfg_err)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic begin_seq(input logic [1:0] code);
        rst_req    = 1'b1;
        start_code = code;
        step(3);
        rst_req = 1'b0;
    endtask

    task automatic send_tick();
        ms_tick = 1'b1;
        step(3);
        ms_tick = 1'b0;
        step(7);
    endtask

    task automatic t_reset_state();
        step(3);
        check("R1", "core_rst in reset", core_rst, 1'b1);
        check("R1", "clk_en in reset", clk_en, 1'b0);
    endtask

    task automatic t_code00();
        begin_seq(2'b00);
        step(5);
        check("R2", "clk_en after 5", clk_en, 1'b0);
        step(1);
        check("R2", "clk_en after 6", clk_en, 1'b1);
        check("R3", "core_rst after 6", core_rst, 1'b1);
        step(13);
        check("R3", "core_rst after 19", core_rst, 1'b1);
        step(1);
        check("R3", "core_rst after 20", core_rst, 1'b0);
    endtask

    task automatic t_pd_wake();
        wake_req = 1'b1;
        step(1);
        wake_req = 1'b0;
        check("R11", "clk_en after wake in run", clk_en, 1'b1);
        check("R11", "core_rst after wake in run", core_rst, 1'b0);
        pd_enter = 1'b1;
        step(1);
        pd_enter = 1'b0;
        check("R9", "clk_en after pd", clk_en, 1'b0);
        check("R9", "core_rst after pd", core_rst, 1'b0);
        step(5);
        check("R9", "clk_en stays off", clk_en, 1'b0);
        wake_req = 1'b1;
        step(1);
        wake_req = 1'b0;
        step(5);
        check("R10", "clk_en 5 after wake", clk_en, 1'b0);
        check("R10", "core_rst during wake", core_rst, 1'b0);
        step(1);
        check("R10", "clk_en 6 after wake", clk_en, 1'b1);
        check("R10", "core_rst after wake", core_rst, 1'b0);
    endtask

    task automatic t_code01();
        begin_seq(2'b01);
        step(25);
        check("R4", "core_rst before ticks", core_rst, 1'b1);
        for (int i = 0; i < 3; i++) send_tick();
        check("R4", "core_rst after 3 ticks", core_rst, 1'b1);
        send_tick();
        check("R4", "core_rst after 4 ticks", core_rst, 1'b0);
        check("R4", "clk_en after release", clk_en, 1'b1);
    endtask

    task automatic t_code10();
        begin_seq(2'b10);
        step(25);
        for (int i = 0; i < 63; i++) send_tick();
        check("R5", "core_rst after 63 ticks", core_rst, 1'b1);
        send_tick();
        check("R5", "core_rst after 64 ticks", core_rst, 1'b0);
    endtask

    task automatic t_latch();
        rst_req    = 1'b1;
        start_code = 2'b01;
        step(3);
        rst_req    = 1'b0;
        start_code = 2'b00;
        step(40);
        check("R7", "code change ignored", core_rst, 1'b1);
        for (int i = 0; i < 4; i++) send_tick();
        check("R7", "latched code release", core_rst, 1'b0);
    endtask

    task automatic t_reserved();
        begin_seq(2'b11);
        check("R6", "cfg_err", cfg_err, 1'b1);
        step(6);
        check("R6", "clk_en with reserved", clk_en, 1'b1);
        step(30);
        for (int i = 0; i < 6; i++) send_tick();
        check("R6", "core_rst held", core_rst, 1'b1);
        check("R6", "cfg_err held", cfg_err, 1'b1);
    endtask

    task automatic t_restart();
        begin_seq(2'b00);
        check("R8", "cfg_err cleared", cfg_err, 1'b0);
        step(20);
        check("R8", "release after restart", core_rst, 1'b0);
        rst_req = 1'b1;
        step(1);
        check("R8", "core_rst from run", core_rst, 1'b1);
        check("R8", "clk_en from run", clk_en, 1'b0);
        rst_req = 1'b0;
        step(25);
        send_tick();
        rst_req    = 1'b1;
        start_code = 2'b10;
        step(2);
        rst_req = 1'b0;
        step(25);
        for (int i = 0; i < 3; i++) send_tick();
        check("R8", "ms count restarted", core_rst, 1'b1);
        begin_seq(2'b00);
        step(19);
        check("R8", "core_rst at 19", core_rst, 1'b1);
        step(1);
        check("R8", "core_rst at 20", core_rst, 1'b0);
    endtask

    initial begin
        t_reset_state();
        t_code00();
        t_pd_wake();
        t_code01();
        t_code10();
        t_latch();
        t_reserved();
        t_restart();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule